// File: doc/BRIEF.md
# Dirty Page Range Scanner

This block walks an I/O virtual address window and reports which mapped pages have been written. A single start pulse supplies the first address, the window length in bytes and a mode bit. For every step the scanner asks an external lookup agent for the leaf descriptor that covers the current address. The agent returns whether a descriptor exists, its location, how many replicated copies map the page, the page level and the first descriptor's contents. The scanner then reads those copies through a 64-bit descriptor memory port.

Dirtiness is the OR of bit 6 over all copies of the page. In clear mode the scanner visits every copy and writes back each one whose bit 6 was set, with that bit cleared. In test-only mode it stops at the first set bit and writes nothing. Each dirty page yields one record with the current address and the page span, held until the consumer takes it. Invalidating translation caches is left to whoever consumes the records. A done pulse closes the walk.

Top module: `dirty_range_scanner`

## Requirements
- R1: The span of a page at level L is 2^(12+9L) bytes. Every record carries that span as its size, and a step whose lookup reports no size advances by 4096 bytes.
- R2: When the lookup reports no descriptor, or bit 0 (present) of the returned descriptor is 0, the step makes no descriptor read, no write and no record.
- R3: For a present page with N replicas at pointer P, copy i is read at P+8*i in ascending i. N=0 is treated as 1. The page is dirty if any copy read has bit 6 set.
- R4: In test-only mode, reading stops at the first copy with bit 6 set, and no descriptor write is made.
- R5: In clear mode every copy is read. Each copy whose bit 6 was set is written back once at its own address, with bit 6 cleared and the other 63 bits unchanged. Copies that were clean are not written.
- R6: A dirty page produces exactly one record whose address is the current walk address, even if that address is not aligned to the page.
- R7: The first step is at the start address. After each step the address grows by the step size, and the walk goes on while the new address is below start+length-1.
- R8: A record stays valid with unchanged address and size until the consumer's ready is high.
- R9: Done is a one-cycle pulse after the final step and after the final record has been taken. Done is never high together with a valid record.
- R10: A start pulse that arrives while a walk is in progress has no effect.
- R11: After reset there is no lookup request, no memory request, no record and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| start_addr_i | input | ADDR_W | First address of the window |
| range_len_i | input | ADDR_W | Window length in bytes (at least 1) |
| test_only_i | input | 1 | 1: test without clearing; 0: test and clear |
| lk_req_o | output | 1 | Lookup request, held until acknowledged |
| lk_addr_o | output | ADDR_W | Address to look up |
| lk_ack_i | input | 1 | Lookup response valid |
| lk_found_i | input | 1 | A descriptor exists for the address |
| lk_size_vld_i | input | 1 | The level field is meaningful |
| lk_level_i | input | LVL_W | Page level of the mapping |
| lk_reps_i | input | REP_W | Number of replicated descriptors |
| lk_ptr_i | input | PTR_W | Byte address of the first replica |
| lk_desc_i | input | 64 | Contents of the first replica |
| mem_req_o | output | 1 | Descriptor memory request, held until granted |
| mem_we_o | output | 1 | 1 for a write-back, 0 for a read |
| mem_addr_o | output | PTR_W | Byte address of the descriptor |
| mem_wdata_o | output | 64 | Write-back value |
| mem_gnt_i | input | 1 | Request completed this cycle |
| mem_rdata_i | input | 64 | Read data, valid with a granted read |
| rec_valid_o | output | 1 | Dirty record available |
| rec_addr_o | output | ADDR_W | Address of the dirty span |
| rec_size_o | output | ADDR_W | Byte size of the dirty span |
| rec_ready_i | input | 1 | Consumer takes the record |
| done_o | output | 1 | Walk finished pulse |

## Verification
A corrupted cursor or latched level shows up at once on the next lookup address or record, which then sits off the arithmetic sequence start + sum of step sizes. A wrong replica index or count shows up within the same page as a read at an unexpected address. It also shows up as a different read total, or as a copy left dirty in the final memory image. Mode confusion shows up as any write during a test-only walk, or as a clear-mode walk that stops early. A stuck state machine shows up as a missing done pulse. The sweep compares the record stream, the read and write totals and the final descriptor image against a model that works out each walk from the rules above.

// File: rtl/drs_pkg.sv
package drs_pkg;
   localparam int DESC_W      = 64;
   localparam int DESC_BYTES  = 8;
   localparam int DIRTY_BIT   = 6;
   localparam int PRESENT_BIT = 0;
   localparam int BASE_SHIFT  = 12;
   localparam int LEVEL_SHIFT = 9;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_READ,
      ST_WRITE,
      ST_EMIT,
      ST_STEP,
      ST_DONE
   } drs_state_e;
endpackage

// File: rtl/drs_page_span.sv
module drs_page_span #(
   parameter int ADDR_W  = 48,
   parameter int LVL_W   = 3,
   parameter int NUM_LVL = 4
) (
   input  logic              size_vld_i,
   input  logic [LVL_W-1:0]  level_i,
   output logic [ADDR_W-1:0] span_o
);
   import drs_pkg::*;

   localparam int TOP_SHIFT = BASE_SHIFT + LEVEL_SHIFT * (NUM_LVL - 1);

   if (TOP_SHIFT >= ADDR_W) begin : g_bad_width
      $error("drs_page_span: largest page does not fit ADDR_W");
   end
   if (NUM_LVL > (1 << LVL_W)) begin : g_bad_lvl
      $error("drs_page_span: LVL_W too narrow for NUM_LVL");
   end

   logic [NUM_LVL-1:0][ADDR_W-1:0] cand;

   for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      localparam int SH = BASE_SHIFT + LEVEL_SHIFT * l;
      assign cand[l] = ADDR_W'(1) << SH;
   end

   always_comb begin
      span_o = ADDR_W'(1) << BASE_SHIFT;
      if (size_vld_i) begin
         for (int l = 0; l < NUM_LVL; l++) begin
            if (level_i == LVL_W'(l)) span_o = cand[l];
         end
      end
   end
endmodule

// File: rtl/drs_range_cursor.sv
module drs_range_cursor #(
   parameter int ADDR_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic [ADDR_W-1:0] load_len_i,
   input  logic              step_i,
   input  logic [ADDR_W-1:0] span_i,
   output logic [ADDR_W-1:0] cur_o,
   output logic              more_o
);
   logic [ADDR_W-1:0] cur_q, last_q, next_addr;

   assign next_addr = cur_q + span_i;
   assign more_o    = next_addr < last_q;
   assign cur_o     = cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         last_q <= '0;
      end else if (load_i) begin
         cur_q  <= load_addr_i;
         last_q <= load_addr_i + load_len_i - ADDR_W'(1);
      end else if (step_i) begin
         cur_q  <= next_addr;
      end
   end
endmodule

// File: rtl/drs_replica_walker.sv
module drs_replica_walker #(
   parameter int PTR_W = 48,
   parameter int REP_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [PTR_W-1:0] base_i,
   input  logic [REP_W-1:0] count_i,
   input  logic             adv_i,
   output logic [PTR_W-1:0] rep_addr_o,
   output logic             last_o
);
   import drs_pkg::*;

   localparam int OFS_SH = $clog2(DESC_BYTES);

   if (REP_W + OFS_SH > PTR_W) begin : g_bad_ptr
      $error("drs_replica_walker: PTR_W too narrow for REP_W replicas");
   end

   logic [PTR_W-1:0] base_q;
   logic [REP_W-1:0] idx_q, cnt_q;

   assign rep_addr_o = base_q + (PTR_W'(idx_q) << OFS_SH);
   assign last_o     = (idx_q == cnt_q - REP_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
         cnt_q  <= REP_W'(1);
      end else if (load_i) begin
         base_q <= base_i;
         idx_q  <= '0;
         cnt_q  <= (count_i == '0) ? REP_W'(1) : count_i;
      end else if (adv_i) begin
         idx_q  <= idx_q + REP_W'(1);
      end
   end
endmodule

// File: rtl/dirty_range_scanner.sv
module dirty_range_scanner #(
   parameter int ADDR_W  = 48,
   parameter int PTR_W   = 48,
   parameter int LVL_W   = 3,
   parameter int NUM_LVL = 4,
   parameter int REP_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [ADDR_W-1:0] range_len_i,
   input  logic              test_only_i,
   output logic              lk_req_o,
   output logic [ADDR_W-1:0] lk_addr_o,
   input  logic              lk_ack_i,
   input  logic              lk_found_i,
   input  logic              lk_size_vld_i,
   input  logic [LVL_W-1:0]  lk_level_i,
   input  logic [REP_W-1:0]  lk_reps_i,
   input  logic [PTR_W-1:0]  lk_ptr_i,
   input  logic [63:0]       lk_desc_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [PTR_W-1:0]  mem_addr_o,
   output logic [63:0]       mem_wdata_o,
   input  logic              mem_gnt_i,
   input  logic [63:0]       mem_rdata_i,
   output logic              rec_valid_o,
   output logic [ADDR_W-1:0] rec_addr_o,
   output logic [ADDR_W-1:0] rec_size_o,
   input  logic              rec_ready_i,
   output logic              done_o
);
   import drs_pkg::*;

   drs_state_e        state_q, state_d;
   logic              test_q;
   logic              dirty_q;
   logic              size_vld_q;
   logic [LVL_W-1:0]  level_q;
   logic [63:0]       wb_q;
   logic [ADDR_W-1:0] cur_addr, span;
   logic              more;
   logic [PTR_W-1:0]  rep_addr;
   logic              rep_last;
   logic              cur_load, cur_step, rep_load, rep_adv;
   logic              hit;
   logic              unused_desc_bits;

   assign unused_desc_bits = ^lk_desc_i[63:1];
   assign hit              = mem_rdata_i[DIRTY_BIT];

   drs_page_span #(.ADDR_W(ADDR_W), .LVL_W(LVL_W), .NUM_LVL(NUM_LVL)) u_span (
      .size_vld_i (size_vld_q),
      .level_i    (level_q),
      .span_o     (span)
   );

   drs_range_cursor #(.ADDR_W(ADDR_W)) u_cursor (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (cur_load),
      .load_addr_i (start_addr_i),
      .load_len_i  (range_len_i),
      .step_i      (cur_step),
      .span_i      (span),
      .cur_o       (cur_addr),
      .more_o      (more)
   );

   drs_replica_walker #(.PTR_W(PTR_W), .REP_W(REP_W)) u_reps (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (rep_load),
      .base_i     (lk_ptr_i),
      .count_i    (lk_reps_i),
      .adv_i      (rep_adv),
      .rep_addr_o (rep_addr),
      .last_o     (rep_last)
   );

   always_comb begin
      state_d  = state_q;
      cur_load = 1'b0;
      cur_step = 1'b0;
      rep_load = 1'b0;
      rep_adv  = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start_i) begin
            cur_load = 1'b1;
            state_d  = ST_LOOK;
         end
         ST_LOOK: if (lk_ack_i) begin
            if (lk_found_i && lk_desc_i[PRESENT_BIT]) begin
               rep_load = 1'b1;
               state_d  = ST_READ;
            end else begin
               state_d  = ST_STEP;
            end
         end
         ST_READ: if (mem_gnt_i) begin
            if (hit && test_q)  state_d = ST_EMIT;
            else if (hit)       state_d = ST_WRITE;
            else if (rep_last)  state_d = dirty_q ? ST_EMIT : ST_STEP;
            else                rep_adv = 1'b1;
         end
         ST_WRITE: if (mem_gnt_i) begin
            if (rep_last) state_d = ST_EMIT;
            else begin
               rep_adv = 1'b1;
               state_d = ST_READ;
            end
         end
         ST_EMIT: if (rec_ready_i) state_d = ST_STEP;
         ST_STEP: begin
            cur_step = 1'b1;
            state_d  = more ? ST_LOOK : ST_DONE;
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         test_q     <= 1'b0;
         dirty_q    <= 1'b0;
         size_vld_q <= 1'b0;
         level_q    <= '0;
         wb_q       <= '0;
      end else begin
         state_q <= state_d;
         if (cur_load) test_q <= test_only_i;
         if (state_q == ST_LOOK && lk_ack_i) begin
            size_vld_q <= lk_size_vld_i;
            level_q    <= lk_level_i;
            dirty_q    <= 1'b0;
         end
         if (state_q == ST_READ && mem_gnt_i && hit) begin
            dirty_q <= 1'b1;
            wb_q    <= mem_rdata_i & ~(64'd1 << DIRTY_BIT);
         end
      end
   end

   assign lk_req_o    = (state_q == ST_LOOK);
   assign lk_addr_o   = cur_addr;
   assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign mem_we_o    = (state_q == ST_WRITE);
   assign mem_addr_o  = rep_addr;
   assign mem_wdata_o = wb_q;
   assign rec_valid_o = (state_q == ST_EMIT);
   assign rec_addr_o  = cur_addr;
   assign rec_size_o  = span;
   assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
   parameter int ADDR_W = 48,
   parameter int PTR_W  = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              test_q,
   input logic              lk_req_o,
   input logic [ADDR_W-1:0] lk_addr_o,
   input logic              lk_ack_i,
   input logic              mem_req_o,
   input logic              mem_we_o,
   input logic [PTR_W-1:0]  mem_addr_o,
   input logic [63:0]       mem_wdata_o,
   input logic              mem_gnt_i,
   input logic              rec_valid_o,
   input logic [ADDR_W-1:0] rec_addr_o,
   input logic [ADDR_W-1:0] rec_size_o,
   input logic              rec_ready_i,
   input logic              done_o
);
   AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_addr_o) && $stable(rec_size_o)); // R8
   AST_SPAN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o |-> $countones(rec_size_o) == 1); // R1
   AST_LOOK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req_o && !lk_ack_i |=> lk_req_o && $stable(lk_addr_o)); // R7
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R3
   AST_WB_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_we_o |-> !mem_wdata_o[6]); // R5
   AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && test_q |-> !mem_we_o); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_DONE_NO_REC: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !rec_valid_o); // R9
   AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lk_req_o, mem_req_o, rec_valid_o, done_o})); // R11
endmodule

bind dirty_range_scanner drs_checker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_drs_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .test_q      (test_q),
   .lk_req_o    (lk_req_o),
   .lk_addr_o   (lk_addr_o),
   .lk_ack_i    (lk_ack_i),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_gnt_i   (mem_gnt_i),
   .rec_valid_o (rec_valid_o),
   .rec_addr_o  (rec_addr_o),
   .rec_size_o  (rec_size_o),
   .rec_ready_i (rec_ready_i),
   .done_o      (done_o)
);

// File: tb/dirty_range_scanner_bench.sv
module dirty_range_scanner_bench;
   localparam int AW = 32;
   localparam int PW = 16;
   localparam int LW = 2;
   localparam int NL = 3;
   localparam int RW = 4;
   localparam longint MB2 = 64'h20_0000;
   localparam longint KB4 = 64'h1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] start_addr_i = '0;
   logic [AW-1:0] range_len_i = '0;
   logic          test_only_i = 1'b0;
   logic          lk_req_o;
   logic [AW-1:0] lk_addr_o;
   logic          lk_ack_i = 1'b0;
   logic          lk_found_i = 1'b0;
   logic          lk_size_vld_i = 1'b0;
   logic [LW-1:0] lk_level_i = '0;
   logic [RW-1:0] lk_reps_i = '0;
   logic [PW-1:0] lk_ptr_i = '0;
   logic [63:0]   lk_desc_i = '0;
   logic          mem_req_o, mem_we_o;
   logic [PW-1:0] mem_addr_o;
   logic [63:0]   mem_wdata_o;
   logic          mem_gnt_i = 1'b0;
   logic [63:0]   mem_rdata_i = '0;
   logic          rec_valid_o;
   logic [AW-1:0] rec_addr_o, rec_size_o;
   logic          rec_ready_i = 1'b0;
   logic          done_o;

   dirty_range_scanner #(.ADDR_W(AW), .PTR_W(PW), .LVL_W(LW), .NUM_LVL(NL), .REP_W(RW))
   u_dirty_range_scanner (.*);

   always #2 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit wd_hit = 1'b0;
   logic [63:0] mem [64];
   logic [63:0] ref_mem [64];
   longint got_addr[$], got_size[$], exp_addr[$], exp_size[$];
   int n_rd = 0, n_wr = 0, n_done = 0, rdy_phase = 0;
   bit pend = 1'b0;
   logic [AW-1:0] held_addr, held_size;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // lookup map: 16 small pages, a hole without size, 5 large pages of 4 copies, then sized holes
   task automatic map_of(input longint iova, output bit found, output bit sv,
                         output int lvl, output int reps, output int ptr);
      found = 0; sv = 0; lvl = 0; reps = 1; ptr = 0;
      if (iova < 16 * KB4) begin
         found = 1; sv = 1; ptr = 8 * int'(iova >> 12);
      end else if (iova < MB2) begin
         found = 0; sv = 0;
      end else if (iova < 6 * MB2) begin
         found = 1; sv = 1; lvl = 1; reps = 4;
         ptr = 8 * (16 + 4 * (int'(iova >> 21) - 1));
      end else begin
         found = 0; sv = 1; lvl = 1;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !wd_hit) begin
         wd_hit = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected below 150000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // responders and monitor, all at the falling edge
   always @(negedge clk) begin
      bit f, sv, r;
      int lv, rp, pt;
      if (lk_ack_i) lk_ack_i = 1'b0;
      else if (lk_req_o) begin
         map_of(longint'(lk_addr_o), f, sv, lv, rp, pt);
         lk_ack_i = 1'b1; lk_found_i = f; lk_size_vld_i = sv;
         lk_level_i = LW'(lv); lk_reps_i = RW'(rp); lk_ptr_i = PW'(pt);
         lk_desc_i = mem[pt[8:3]];
      end
      if (mem_gnt_i) mem_gnt_i = 1'b0;
      else if (mem_req_o) begin
         mem_gnt_i = 1'b1;
         if (mem_we_o) begin
            mem[mem_addr_o[8:3]] = mem_wdata_o;
            n_wr++;
         end else begin
            mem_rdata_i = mem[mem_addr_o[8:3]];
            n_rd++;
         end
      end
      if (done_o) n_done++;
      rdy_phase++;
      r = (rdy_phase % 3) != 0;
      if (rec_valid_o && pend)
         chk(rec_addr_o == held_addr && rec_size_o == held_size, "R8", "held record",
             longint'(rec_addr_o), longint'(held_addr));
      if (rec_valid_o && r) begin
         got_addr.push_back(longint'(rec_addr_o));
         got_size.push_back(longint'(rec_size_o));
      end
      pend = rec_valid_o && !r;
      held_addr = rec_addr_o; held_size = rec_size_o;
      rec_ready_i = r;
   end

   task automatic init_mem(input int s);
      for (int i = 0; i < 64; i++) begin
         bit pres = ((i * 7 + s) % 5) != 0;
         bit dirt = (((i * 3 + s * 5) % 4) == 0) || (s == 3);
         mem[i] = {32'hC0DE0000 + 32'(i), 24'h0, 1'b0, dirt, 5'b00101, pres};
         ref_mem[i] = mem[i];
      end
   endtask

   task automatic model(input longint st, input longint len, input bit tonly,
                        output int erd, output int ewr);
      longint iova = st, last = st + len - 1, span;
      bit f, sv, dirty;
      int lv, rp, pt;
      erd = 0; ewr = 0;
      exp_addr.delete(); exp_size.delete();
      do begin
         map_of(iova, f, sv, lv, rp, pt);
         span = sv ? (64'd1 << (12 + 9 * lv)) : KB4;
         if (f && ref_mem[pt[8:3]][0]) begin
            dirty = 0;
            for (int i = 0; i < rp; i++) begin
               int k = pt / 8 + i;
               erd++;
               if (ref_mem[k][6]) begin
                  dirty = 1;
                  if (tonly) break;
                  ref_mem[k][6] = 1'b0;
                  ewr++;
               end
            end
            if (dirty) begin
               exp_addr.push_back(iova);
               exp_size.push_back(span);
            end
         end
         iova += span;
      end while (iova < last);
   endtask

   task automatic run(input int s, input bit tonly, input longint st, input longint len);
      int erd, ewr, bad;
      init_mem(s);
      model(st, len, tonly, erd, ewr);
      got_addr.delete(); got_size.delete();
      n_rd = 0; n_wr = 0; n_done = 0;
      @(negedge clk);
      start_i = 1'b1; start_addr_i = AW'(st); range_len_i = AW'(len); test_only_i = tonly;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      // R10: a second start in mid-walk must change nothing
      start_i = 1'b1; start_addr_i = AW'(MB2); range_len_i = AW'(KB4); test_only_i = !tonly;
      @(negedge clk);
      start_i = 1'b0;
      while (n_done == 0 && !wd_hit) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(n_done == 1, "R9 R10", "done pulses", n_done, 1);
      chk(got_addr.size() == exp_addr.size(), "R2 R7", "record count",
          got_addr.size(), exp_addr.size());
      for (int i = 0; i < got_addr.size() && i < exp_addr.size(); i++) begin
         chk(got_addr[i] == exp_addr[i], "R6", "record address", got_addr[i], exp_addr[i]);
         chk(got_size[i] == exp_size[i], "R1", "record size", got_size[i], exp_size[i]);
      end
      chk(n_rd == erd, tonly ? "R4" : "R3", "descriptor reads", n_rd, erd);
      chk(n_wr == ewr, tonly ? "R4" : "R5", "descriptor writes", n_wr, ewr);
      bad = 0;
      for (int i = 0; i < 64; i++) if (mem[i] !== ref_mem[i]) bad++;
      chk(bad == 0, "R5", "descriptor image mismatches", bad, 0);
   endtask

   initial begin
      longint starts [5];
      longint lens [5];
      starts[0] = 0;               lens[0] = 16 * KB4;
      starts[1] = MB2;             lens[1] = 5 * MB2;
      starts[2] = 64'hE000;        lens[2] = MB2;
      starts[3] = 6 * MB2;         lens[3] = 3 * MB2;
      starts[4] = MB2 + 64'h3000;  lens[4] = 2 * MB2;
      repeat (3) @(negedge clk);
      chk(!lk_req_o && !mem_req_o && !rec_valid_o && !done_o, "R11", "idle outputs in reset",
          {lk_req_o, mem_req_o, rec_valid_o, done_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!lk_req_o && !mem_req_o && !rec_valid_o && !done_o, "R11", "idle outputs after reset",
          {lk_req_o, mem_req_o, rec_valid_o, done_o}, 0);
      for (int s = 0; s < 4; s++)
         for (int m = 0; m < 2; m++)
            for (int r = 0; r < 5; r++)
               run(s, m[0], starts[r], lens[r]);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule